// File: doc/BRIEF.md
# CPU Interrupt Acceptance Controller

This block is the interrupt-control slice of an 8-bit CPU core. It holds the two interrupt enable flags and the selected interrupt mode. It also decides, at each instruction boundary, whether the core must leave the instruction stream to service a request. Two requests are watched. The maskable request is an active-low level, and it is honoured only while the primary enable flag is set. The non-maskable request is an active-low input whose falling edge is latched. It is always honoured.

The instruction decoder sends one-cycle strobes alongside the boundary pulse of the instruction that is completing: disable, enable, return-from-interrupt, return-from-NMI, and set-mode with a 2-bit mode selector. When a request is accepted, the block reports which kind of entry to perform. For a fixed-address entry it also gives the 16-bit call address, and for a table entry it gives the table pointer. The core performs the stack push, the table read, or the fetch of an opcode from the data bus. The high pointer byte comes from the core's interrupt page register, and the low byte comes from the device's byte on the data bus.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset, both enable flags read 0, the mode reads 0, and no request is accepted.
- R2: A maskable request (int_ni low) is accepted only in a cycle with boundary_i high, while iff1 is set and no NMI is pending. accept_o is asserted in that same cycle and never outside a boundary.
- R3: At a boundary, the disable strobe clears both flags and the enable strobe sets both. No maskable request is accepted at the boundary where either strobe completes.
- R4: After the enable strobe, a held maskable request is accepted at the next boundary, not at the enable boundary itself.
- R5: Accepting a maskable request clears both iff1 and iff2.
- R6: Accepting an NMI stores the flag value left by the completing instruction into iff2 and clears iff1. The return-from-NMI strobe copies iff2 into iff1. The return-from-interrupt strobe leaves both flags unchanged.
- R7: An NMI is accepted whatever the state of iff1. Its target is 0066h, and nmi_taken_o is asserted with it.
- R8: In mode 1, an accepted maskable request targets the fixed address 0038h.
- R9: In mode 0, an accepted maskable request asserts bus_exec_o and drives the target as 0000h.
- R10: In mode 2, an accepted maskable request asserts vector_read_o, with the target being {i_reg_i, vec_byte_i}.
- R11: A set-mode strobe with im_sel_i of 0, 1 or 2 selects that mode. A value of 3 leaves the mode unchanged. A new mode already governs an acceptance at the same boundary.
- R12: One falling edge of nmi_ni is held pending until one NMI acceptance, even if the pin stays low. A pending NMI wins over a maskable request. At most one of nmi_taken_o, vector_read_o and bus_exec_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | High in the cycle where an instruction completes |
| di_i | input | 1 | Disable strobe from decoder |
| ei_i | input | 1 | Enable strobe from decoder |
| reti_i | input | 1 | Return-from-interrupt strobe |
| retn_i | input | 1 | Return-from-NMI strobe |
| im_set_i | input | 1 | Set-mode strobe |
| im_sel_i | input | 2 | Mode number for im_set_i |
| int_ni | input | 1 | Maskable request, active-low level |
| nmi_ni | input | 1 | Non-maskable request, falling edge |
| i_reg_i | input | 8 | Interrupt page register (table pointer high byte) |
| vec_byte_i | input | 8 | Device byte from the data bus |
| accept_o | output | 1 | Request accepted at this boundary |
| nmi_taken_o | output | 1 | Accepted request is the NMI |
| vector_read_o | output | 1 | Target is a table pointer to read |
| bus_exec_o | output | 1 | Execute the opcode the device places on the bus |
| target_addr_o | output | 16 | Call address or table pointer |
| iff1_o | output | 1 | Primary enable flag |
| iff2_o | output | 1 | Saved enable flag |
| mode_o | output | 2 | Current interrupt mode |

## Verification
The hardest state to reach is an NMI entry while a maskable request is held low and enabled. The test must then get past the return-from-NMI boundary and show that the maskable request is refused while iff1 is clear, and that it is taken only one boundary after iff1 is restored. The stimulus enables the flags, drives int_ni low, and pulses nmi_ni between boundaries. It then steps boundary by boundary, checking the accept kind and the flags after each one. A second hard case is an NMI edge whose pin stays low through its service and the next boundary. It confirms that a single edge is served exactly once.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  typedef enum logic [1:0] {
    IM_BUS   = 2'd0,
    IM_FIXED = 2'd1,
    IM_TABLE = 2'd2
  } irq_mode_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_ni,
  input  logic take_i,
  output logic pend_o
);
  logic prev_q, pend_q, fall;

  assign fall = prev_q & ~nmi_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= nmi_ni;
      // a fresh edge outranks the clear of the one being serviced
      if (fall)        pend_q <= 1'b1;
      else if (take_i) pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;

  // R12
  edge_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nmi_ni) |=> pend_q);
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_accept_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      boundary_i,
  input  logic      di_i,
  input  logic      ei_i,
  input  logic      reti_i,
  input  logic      retn_i,
  input  logic      im_set_i,
  input  logic [1:0] im_sel_i,
  input  logic      take_int_i,
  input  logic      take_nmi_i,
  output logic      iff1_o,
  output logic      iff2_o,
  output irq_mode_e mode_o,
  output irq_mode_e mode_eff_o
);
  logic      iff1_q, iff2_q, f1, f2, n1, n2;
  irq_mode_e mode_q, mode_d;

  // effect of the completing instruction first
  always_comb begin
    f1 = iff1_q;
    f2 = iff2_q;
    if (boundary_i) begin
      if (di_i) begin
        f1 = 1'b0;
        f2 = 1'b0;
      end else if (ei_i) begin
        f1 = 1'b1;
        f2 = 1'b1;
      end else if (retn_i) begin
        f1 = iff2_q;
      end else if (reti_i) begin
        f1 = iff1_q;
        f2 = iff2_q;
      end
    end
  end

  // then the entry sequence
  always_comb begin
    n1 = f1;
    n2 = f2;
    if (take_nmi_i) begin
      n2 = f1;
      n1 = 1'b0;
    end else if (take_int_i) begin
      n1 = 1'b0;
      n2 = 1'b0;
    end
  end

  always_comb begin
    mode_d = mode_q;
    if (boundary_i && im_set_i && (im_sel_i != 2'd3))
      mode_d = irq_mode_e'(im_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      mode_q <= IM_BUS;
    end else begin
      iff1_q <= n1;
      iff2_q <= n2;
      mode_q <= mode_d;
    end
  end

  assign iff1_o     = iff1_q;
  assign iff2_o     = iff2_q;
  assign mode_o     = mode_q;
  assign mode_eff_o = mode_d;

  // R2
  int_needs_iff1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_int_i |-> iff1_q);
  // R5
  int_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_int_i |=> (!iff1_q && !iff2_q));
  // R6
  nmi_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_nmi_i && !di_i && !ei_i && !retn_i) |=> (!iff1_q && iff2_q == $past(iff1_q)));
  // R6
  reti_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && reti_i && !take_int_i && !take_nmi_i) |=> ($stable(iff1_q) && $stable(iff2_q)));
  // R3
  ei_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && ei_i && !take_nmi_i) |=> (iff1_q && iff2_q));
endmodule

// File: rtl/irq_target_gen.sv
module irq_target_gen
  import irq_accept_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NMI_VEC   = 'h66,
  parameter int unsigned FIXED_VEC = 'h38,
  localparam int unsigned ADDR_W   = 2 * DATA_W
) (
  input  logic              take_nmi_i,
  input  logic              take_int_i,
  input  irq_mode_e         mode_i,
  input  logic [DATA_W-1:0] i_reg_i,
  input  logic [DATA_W-1:0] vec_byte_i,
  output logic [ADDR_W-1:0] target_o,
  output logic              vector_read_o,
  output logic              bus_exec_o
);
  always_comb begin
    target_o      = '0;
    vector_read_o = 1'b0;
    bus_exec_o    = 1'b0;
    if (take_nmi_i) begin
      target_o = ADDR_W'(NMI_VEC);
    end else if (take_int_i) begin
      unique case (mode_i)
        IM_FIXED: target_o = ADDR_W'(FIXED_VEC);
        IM_TABLE: begin
          target_o      = {i_reg_i, vec_byte_i};
          vector_read_o = 1'b1;
        end
        default:  bus_exec_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NMI_VEC   = 'h66,
  parameter int unsigned FIXED_VEC = 'h38,
  localparam int unsigned ADDR_W   = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boundary_i,
  input  logic              di_i,
  input  logic              ei_i,
  input  logic              reti_i,
  input  logic              retn_i,
  input  logic              im_set_i,
  input  logic [1:0]        im_sel_i,
  input  logic              int_ni,
  input  logic              nmi_ni,
  input  logic [DATA_W-1:0] i_reg_i,
  input  logic [DATA_W-1:0] vec_byte_i,
  output logic              accept_o,
  output logic              nmi_taken_o,
  output logic              vector_read_o,
  output logic              bus_exec_o,
  output logic [ADDR_W-1:0] target_addr_o,
  output logic              iff1_o,
  output logic              iff2_o,
  output logic [1:0]        mode_o
);
  logic      nmi_pend, take_nmi, take_int, iff1, iff2;
  irq_mode_e mode_q, mode_eff;

  assign take_nmi = boundary_i & nmi_pend;
  // enable/disable completing here masks this boundary
  assign take_int = boundary_i & ~nmi_pend & ~int_ni & iff1 & ~ei_i & ~di_i;

  irq_nmi_latch u_nmi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_ni (nmi_ni),
    .take_i (take_nmi),
    .pend_o (nmi_pend)
  );

  irq_flag_ctrl u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .boundary_i (boundary_i),
    .di_i       (di_i),
    .ei_i       (ei_i),
    .reti_i     (reti_i),
    .retn_i     (retn_i),
    .im_set_i   (im_set_i),
    .im_sel_i   (im_sel_i),
    .take_int_i (take_int),
    .take_nmi_i (take_nmi),
    .iff1_o     (iff1),
    .iff2_o     (iff2),
    .mode_o     (mode_q),
    .mode_eff_o (mode_eff)
  );

  irq_target_gen #(
    .DATA_W    (DATA_W),
    .NMI_VEC   (NMI_VEC),
    .FIXED_VEC (FIXED_VEC)
  ) u_target (
    .take_nmi_i    (take_nmi),
    .take_int_i    (take_int),
    .mode_i        (mode_eff),
    .i_reg_i       (i_reg_i),
    .vec_byte_i    (vec_byte_i),
    .target_o      (target_addr_o),
    .vector_read_o (vector_read_o),
    .bus_exec_o    (bus_exec_o)
  );

  assign accept_o    = take_nmi | take_int;
  assign nmi_taken_o = take_nmi;
  assign iff1_o      = iff1;
  assign iff2_o      = iff2;
  assign mode_o      = mode_q;

  // R2
  no_accept_off_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |-> !accept_o);
  // R4
  ei_blocks_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_i && (ei_i || di_i)) |-> !(accept_o && !nmi_taken_o));
  // R12
  kind_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({nmi_taken_o, vector_read_o, bus_exec_o}));
  // R8
  fixed_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && !nmi_taken_o && mode_o == 2'd1 && !im_set_i) |-> (target_addr_o == 16'h0038));
  // R7
  nmi_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_taken_o |-> (accept_o && target_addr_o == 16'h0066));
endmodule

// File: tb/irq_accept_ctrl_tb_top.sv
module irq_accept_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 1'b0, di = 1'b0, ei = 1'b0, reti = 1'b0, retn = 1'b0, ims = 1'b0;
  logic [1:0] im_sel = 2'd0;
  logic int_n = 1'b1, nmi_n = 1'b1;
  logic [7:0] i_reg = 8'h00, vec = 8'h00;
  logic acc, nmi_t, vr, bx, iff1, iff2;
  logic [15:0] tgt;
  logic [1:0] mode;
  logic c_acc, c_nmi, c_vr, c_bx;
  logic [15:0] c_tgt;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  localparam logic [4:0] S_NONE = 5'b00000, S_DI = 5'b10000, S_EI = 5'b01000,
                         S_RETI = 5'b00100, S_RETN = 5'b00010, S_IM = 5'b00001;

  always #2.5 clk = ~clk;

  irq_accept_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .di_i(di), .ei_i(ei),
    .reti_i(reti), .retn_i(retn), .im_set_i(ims), .im_sel_i(im_sel),
    .int_ni(int_n), .nmi_ni(nmi_n), .i_reg_i(i_reg), .vec_byte_i(vec),
    .accept_o(acc), .nmi_taken_o(nmi_t), .vector_read_o(vr), .bus_exec_o(bx),
    .target_addr_o(tgt), .iff1_o(iff1), .iff2_o(iff2), .mode_o(mode)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic b, input logic [4:0] st, input logic [1:0] sel);
    boundary = b;
    {di, ei, reti, retn, ims} = st;
    im_sel = sel;
    #1;
    c_acc = acc; c_nmi = nmi_t; c_vr = vr; c_bx = bx; c_tgt = tgt;
    @(negedge clk);
    boundary = 1'b0;
    {di, ei, reti, retn, ims} = S_NONE;
  endtask

  task automatic nmi_pulse();
    nmi_n = 1'b0;
    @(negedge clk);
    nmi_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 iff1", 16'(iff1), 16'h0);
    chk("R1 iff2", 16'(iff2), 16'h0);
    chk("R1 mode", 16'(mode), 16'h0);
    int_n = 1'b0;
    step(1'b1, S_NONE, 2'd0);
    chk("R1 no accept", 16'(c_acc), 16'h0);
    int_n = 1'b1;
  endtask

  task automatic t_ei_mode0();
    int_n = 1'b0;
    step(1'b1, S_EI, 2'd0);
    chk("R4 blocked at enable", 16'(c_acc), 16'h0);
    chk("R3 enable sets iff1", 16'(iff1), 16'h1);
    chk("R3 enable sets iff2", 16'(iff2), 16'h1);
    step(1'b1, S_NONE, 2'd0);
    chk("R4 taken next boundary", 16'(c_acc), 16'h1);
    chk("R9 bus exec", 16'(c_bx), 16'h1);
    chk("R9 target", c_tgt, 16'h0000);
    chk("R5 iff1 cleared", 16'(iff1), 16'h0);
    chk("R5 iff2 cleared", 16'(iff2), 16'h0);
    int_n = 1'b1;
  endtask

  task automatic t_off_boundary();
    step(1'b1, S_EI, 2'd0);
    int_n = 1'b0;
    step(1'b0, S_NONE, 2'd0);
    chk("R2 off boundary", 16'(c_acc), 16'h0);
    step(1'b1, S_NONE, 2'd0);
    chk("R2 at boundary", 16'(c_acc), 16'h1);
    int_n = 1'b1;
  endtask

  task automatic t_mode1();
    step(1'b1, S_IM, 2'd1);
    chk("R11 mode 1", 16'(mode), 16'h1);
    step(1'b1, S_EI, 2'd0);
    int_n = 1'b0;
    step(1'b1, S_NONE, 2'd0);
    chk("R8 accept", 16'(c_acc), 16'h1);
    chk("R8 target", c_tgt, 16'h0038);
    chk("R8 kind", {14'd0, c_vr, c_bx}, 16'h0);
    int_n = 1'b1;
  endtask

  task automatic t_mode2();
    i_reg = 8'h80; vec = 8'h81;
    step(1'b1, S_IM, 2'd2);
    step(1'b1, S_EI, 2'd0);
    int_n = 1'b0;
    step(1'b1, S_NONE, 2'd0);
    chk("R10 table read", 16'(c_vr), 16'h1);
    chk("R10 pointer", c_tgt, 16'h8081);
    int_n = 1'b1;
    step(1'b1, S_IM, 2'd3);
    chk("R11 sel 3 ignored", 16'(mode), 16'h2);
  endtask

  task automatic t_same_boundary_mode();
    step(1'b1, S_EI, 2'd0);
    int_n = 1'b0;
    step(1'b1, S_IM, 2'd1);
    chk("R11 new mode same boundary", c_tgt, 16'h0038);
    int_n = 1'b1;
  endtask

  task automatic t_di();
    step(1'b1, S_EI, 2'd0);
    int_n = 1'b0;
    step(1'b1, S_DI, 2'd0);
    chk("R3 blocked at disable", 16'(c_acc), 16'h0);
    chk("R3 disable flags", {14'd0, iff1, iff2}, 16'h0);
    step(1'b1, S_NONE, 2'd0);
    chk("R3 masked after disable", 16'(c_acc), 16'h0);
    int_n = 1'b1;
  endtask

  task automatic t_reti();
    step(1'b1, S_EI, 2'd0);
    step(1'b1, S_RETI, 2'd0);
    chk("R6 reti keeps flags", {14'd0, iff1, iff2}, 16'h3);
    step(1'b1, S_DI, 2'd0);
  endtask

  task automatic t_nmi_held();
    step(1'b1, S_EI, 2'd0);
    nmi_n = 1'b0;
    @(negedge clk);
    step(1'b0, S_NONE, 2'd0);
    chk("R12 not off boundary", 16'(c_acc), 16'h0);
    step(1'b1, S_NONE, 2'd0);
    chk("R7 nmi accept", {14'd0, c_acc, c_nmi}, 16'h3);
    chk("R7 nmi target", c_tgt, 16'h0066);
    chk("R6 nmi entry flags", {14'd0, iff1, iff2}, 16'h1);
    step(1'b1, S_RETN, 2'd0);
    chk("R12 one service per edge", 16'(c_acc), 16'h0);
    chk("R6 retn restores", 16'(iff1), 16'h1);
    nmi_n = 1'b1;
    step(1'b1, S_DI, 2'd0);
  endtask

  task automatic t_nmi_masked();
    nmi_pulse();
    step(1'b1, S_NONE, 2'd0);
    chk("R7 nmi with iff1 clear", 16'(c_nmi), 16'h1);
    chk("R6 saved zero", {14'd0, iff1, iff2}, 16'h0);
  endtask

  task automatic t_priority();
    step(1'b1, S_EI, 2'd0);
    int_n = 1'b0;
    nmi_pulse();
    step(1'b1, S_NONE, 2'd0);
    chk("R12 nmi wins", {c_nmi, c_tgt[14:0]}, 16'h8066);
    step(1'b1, S_NONE, 2'd0);
    chk("R2 masked in nmi", 16'(c_acc), 16'h0);
    step(1'b1, S_RETN, 2'd0);
    chk("R6 retn boundary no int", 16'(c_acc), 16'h0);
    chk("R6 iff1 back", 16'(iff1), 16'h1);
    step(1'b1, S_NONE, 2'd0);
    chk("R2 int after retn", {14'd0, c_acc, c_nmi}, 16'h2);
    int_n = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ei_mode0();
    t_off_boundary();
    t_mode1();
    t_mode2();
    t_same_boundary_mode();
    t_di();
    t_reti();
    t_nmi_held();
    t_nmi_masked();
    t_priority();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule